// File: doc/BRIEF.md
# Audio FIFO with Level DMA Event Control

This block buffers serial audio words between the pin-side serializers and a DMA engine. It holds two independent FIFOs, one per direction. Each FIFO is 64 entries deep and 32 bits wide. In the receive direction the pins push words and the DMA pops them. In the transmit direction the DMA pushes words and the pins pop them. Each direction drives a level-type DMA event towards the DMA engine.

Each direction has its own programmable word threshold. Each time a threshold's worth of words has crossed the pin side, one request is added. Each time the DMA has moved a threshold's worth of words, one request is retired. The event output is high while any request is outstanding. Because requests are counted rather than held in a single flag, a request raised and a request retired on the same or neighbouring cycles cannot cancel each other.

A pin-side push into a full receive FIFO and a pin-side pop from an empty transmit FIFO are refused, and each raises a sticky error flag.

Top module: `aud_dma_fifo`

## Requirements
- R1: After a synchronous active-low reset, both FIFOs are empty, `rx_event` is 0, `rx_overflow` and `tx_underflow` are 0, and `tx_event` is 1, because one transmit request is outstanding so that the DMA fills the first batch.
- R2: Each FIFO holds up to 64 words of 32 bits and returns them in arrival order. The oldest word is visible on `rx_dma_data` / `tx_pin_data` while the FIFO is not empty.
- R3: A receive pin push (`rx_pin_valid`=1) while 64 words are held is dropped, leaves the stored words unchanged, and sets `rx_overflow`, which stays 1 until reset. It stays 0 while no push is ever refused.
- R4: A transmit pin pop (`tx_pin_rd`=1) while the transmit FIFO is empty moves no word and sets `tx_underflow`, which stays 1 until reset.
- R5: When an accepted receive pin push brings the count of pushes since the last request to `cfg_rx_thr`, a request is added, and `rx_event` is 1 in the cycle after that clock edge.
- R6: When an accepted receive DMA pop brings the count of pops since the last retirement to `cfg_rx_thr`, one outstanding request is retired. `rx_event` falls in the next cycle only if none is left.
- R7: The transmit direction mirrors R5 and R6. Each `cfg_tx_thr` accepted pin pops add a request, each `cfg_tx_thr` accepted DMA pushes retire one, and `tx_event` reflects whether any request is outstanding.
- R8: When a request is added and one is retired on the same clock edge, or on adjacent edges, the outstanding count ends at least at 1, so the event is 1 in the following cycle and no request is lost.
- R9: Requests accumulate. Two thresholds' worth of pin traffic before any DMA service need two thresholds' worth of DMA traffic before the event falls.
- R10: Refused transfers count towards no threshold and leave the FIFO contents unchanged. These are a receive DMA pop on an empty FIFO and a transmit DMA push on a full FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rx_thr | input | 6 | Receive threshold in words, 1 to 32 |
| cfg_tx_thr | input | 6 | Transmit threshold in words, 1 to 32 |
| rx_pin_valid | input | 1 | Pin side pushes `rx_pin_data` this cycle |
| rx_pin_data | input | 32 | Received audio word |
| rx_dma_rd | input | 1 | DMA pops the oldest receive word this cycle |
| rx_dma_data | output | 32 | Oldest receive word |
| rx_event | output | 1 | Receive DMA request level |
| rx_overflow | output | 1 | Sticky: a receive pin push was refused |
| tx_dma_wr | input | 1 | DMA pushes `tx_dma_data` this cycle |
| tx_dma_data | input | 32 | Word to transmit |
| tx_pin_rd | input | 1 | Pin side pops the oldest transmit word this cycle |
| tx_pin_data | output | 32 | Oldest transmit word |
| tx_event | output | 1 | Transmit DMA request level |
| tx_underflow | output | 1 | Sticky: a transmit pin pop found the FIFO empty |

## Verification
Every result is registered one edge after its stimulus: event levels, error flags and the head word all move on the edge that samples the strobe. The bench therefore drives strobes at a falling edge and compares all outputs against its queue-based model at the next falling edge. The model applies the same strobes at the rising edge in between, using the FIFO occupancy from before that edge. Same-cycle and one-cycle-apart add/retire pairs are built by counting pushes and pops up to one below the threshold on both sides, then firing the final strobes together or on consecutive cycles.

// File: rtl/aud_fifo_pkg.sv
// Shared constants and types for the audio DMA FIFO.
// Assumes: thresholds never exceed half of the FIFO depth.
package aud_fifo_pkg;
    localparam int AUD_DATA_W  = 32;
    localparam int AUD_DEPTH   = 64;
    localparam int AUD_MAX_THR = 32;

    // Action applied to a pending-request counter on one edge
    typedef enum logic [1:0] {
        EV_HOLD   = 2'd0,
        EV_RAISE  = 2'd1,
        EV_RETIRE = 2'd2
    } ev_act_e;
endpackage

// File: rtl/aud_sync_fifo.sv
// Single-clock FIFO with show-ahead read data and a sticky error flag.
// FLAG_WRITE picks which refused access sets the flag:
// 1 = a push into a full FIFO, 0 = a pop from an empty FIFO.
// Refused accesses change nothing but the flag.
// Assumes: DEPTH is at least 2.
module aud_sync_fifo #(
    parameter int DATA_W     = 32,
    parameter int DEPTH      = 64,
    parameter bit FLAG_WRITE = 1'b1,
    localparam int AW        = $clog2(DEPTH),
    localparam int CW        = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_ok,
    output logic              rd_ok,
    output logic              err_flag
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;
    logic [CW-1:0]     count;
    logic              full;
    logic              empty;
    logic              bad_op;

    // Occupancy decode and access acceptance
    always_comb begin
        full  = (count == FULL_CNT);
        empty = (count == '0);
        wr_ok = wr && !full;
        rd_ok = rd && !empty;
    end

    // Pick the refused access that raises the error flag
    generate
        if (FLAG_WRITE) begin : g_flag_wr
            assign bad_op = wr && full;
        end else begin : g_flag_rd
            assign bad_op = rd && empty;
        end
    endgenerate

    // Storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    // Write pointer advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
        end else if (wr_ok) begin
            wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
        end
    end

    // Read pointer advance with wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
        end else if (rd_ok) begin
            rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Occupancy count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_flag <= 1'b0;
        end else if (bad_op) begin
            err_flag <= 1'b1;
        end
    end

    // Head word shown ahead of the pop
    assign rd_data = mem[rd_ptr];

    // R2: occupancy never exceeds the depth
    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R3 / R10: a push into a full FIFO with no pop leaves occupancy unchanged
    p_full_push_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr && full && !rd |=> count == $past(count));

    // R4: a pop from an empty FIFO with no push leaves it empty
    p_empty_pop_dropped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd && empty && !wr |=> count == '0);

    // R3 / R4: once set, the error flag holds until reset
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag |=> err_flag);
endmodule

// File: rtl/aud_evt_ctrl.sv
// Level DMA event generator for one direction.
// Counts accepted pin-side moves and accepted DMA-side moves against a
// threshold. Every completed pin-side batch adds one pending request and
// every completed DMA-side batch retires one. The event is high while any
// request is pending. INIT_PEND sets the pending count after reset.
// Assumes: thr is held stable and lies in 1..MAX_THR.
module aud_evt_ctrl
    import aud_fifo_pkg::*;
#(
    parameter int DEPTH     = 64,
    parameter int MAX_THR   = 32,
    parameter int INIT_PEND = 0,
    localparam int THR_W    = $clog2(MAX_THR) + 1,
    localparam int PEND_W   = $clog2(DEPTH + 1) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [THR_W-1:0] thr,
    input  logic             pin_move,
    input  logic             dma_move,
    output logic             evt
);
    localparam logic [PEND_W-1:0] PEND_MAX  = '1;
    localparam logic [PEND_W-1:0] PEND_INIT = PEND_W'(INIT_PEND);
    localparam logic [THR_W:0]    ONE       = (THR_W+1)'(1);

    logic [THR_W-1:0]  pin_cnt;
    logic [THR_W-1:0]  dma_cnt;
    logic [PEND_W-1:0] pend;
    logic              pin_done;
    logic              dma_done;
    ev_act_e           act;

    // Detect batch completion on each side
    always_comb begin
        pin_done = pin_move && (({1'b0, pin_cnt} + ONE) >= {1'b0, thr});
        dma_done = dma_move && (({1'b0, dma_cnt} + ONE) >= {1'b0, thr});
    end

    // Decide the pending-count action; coincident add and retire keeps the count
    always_comb begin
        if (pin_done && dma_done && (pend != '0)) begin
            act = EV_HOLD;
        end else if (pin_done && (pend != PEND_MAX)) begin
            act = EV_RAISE;
        end else if (dma_done && !pin_done && (pend != '0)) begin
            act = EV_RETIRE;
        end else begin
            act = EV_HOLD;
        end
    end

    // Pin-side word counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_cnt <= '0;
        end else if (pin_done) begin
            pin_cnt <= '0;
        end else if (pin_move) begin
            pin_cnt <= pin_cnt + 1'b1;
        end
    end

    // DMA-side word counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_cnt <= '0;
        end else if (dma_done) begin
            dma_cnt <= '0;
        end else if (dma_move) begin
            dma_cnt <= dma_cnt + 1'b1;
        end
    end

    // Pending request counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= PEND_INIT;
        end else begin
            case (act)
                EV_RAISE:  pend <= pend + 1'b1;
                EV_RETIRE: pend <= pend - 1'b1;
                default:   pend <= pend;
            endcase
        end
    end

    // Event level towards the DMA
    assign evt = (pend != '0);

    // R5: threshold stays legal while running
    p_thr_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (thr != '0) && (thr <= THR_W'(MAX_THR)));

    // R5: a completed pin-side batch leaves the event high
    p_batch_raises_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pin_done |=> evt);

    // R8: add and retire on the same edge never lose a request
    p_coincident_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pin_done && dma_done |=> evt);

    // R6: a lone retirement removes exactly one pending request
    p_retire_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done && !pin_done && (pend != '0) |=> pend == $past(pend) - 1'b1);

    // R6: with nothing pending and nothing added, the event stays low
    p_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !evt && !pin_done |=> !evt);
endmodule

// File: rtl/aud_dma_fifo.sv
// Two-direction audio FIFO with level DMA events.
// Receive: pins push, DMA pops; a refused pin push sets rx_overflow.
// Transmit: DMA pushes, pins pop; a refused pin pop sets tx_underflow.
// Each direction owns an event controller with its own threshold. The
// transmit controller starts with one pending request so that the DMA
// fills the first batch.
// Assumes: thresholds in 1..MAX_THR, multiples of the active serializer count.
module aud_dma_fifo
    import aud_fifo_pkg::*;
#(
    parameter int DATA_W  = AUD_DATA_W,
    parameter int DEPTH   = AUD_DEPTH,
    parameter int MAX_THR = AUD_MAX_THR,
    localparam int THR_W  = $clog2(MAX_THR) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [THR_W-1:0]  cfg_rx_thr,
    input  logic [THR_W-1:0]  cfg_tx_thr,
    input  logic              rx_pin_valid,
    input  logic [DATA_W-1:0] rx_pin_data,
    input  logic              rx_dma_rd,
    output logic [DATA_W-1:0] rx_dma_data,
    output logic              rx_event,
    output logic              rx_overflow,
    input  logic              tx_dma_wr,
    input  logic [DATA_W-1:0] tx_dma_data,
    input  logic              tx_pin_rd,
    output logic [DATA_W-1:0] tx_pin_data,
    output logic              tx_event,
    output logic              tx_underflow
);
    logic rx_wr_ok;
    logic rx_rd_ok;
    logic tx_wr_ok;
    logic tx_rd_ok;

    // Receive storage: pin side pushes, DMA pops
    aud_sync_fifo #(
        .DATA_W     (DATA_W),
        .DEPTH      (DEPTH),
        .FLAG_WRITE (1'b1)
    ) u_rx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (rx_pin_valid),
        .wr_data  (rx_pin_data),
        .rd       (rx_dma_rd),
        .rd_data  (rx_dma_data),
        .wr_ok    (rx_wr_ok),
        .rd_ok    (rx_rd_ok),
        .err_flag (rx_overflow)
    );

    // Transmit storage: DMA pushes, pin side pops
    aud_sync_fifo #(
        .DATA_W     (DATA_W),
        .DEPTH      (DEPTH),
        .FLAG_WRITE (1'b0)
    ) u_tx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (tx_dma_wr),
        .wr_data  (tx_dma_data),
        .rd       (tx_pin_rd),
        .rd_data  (tx_pin_data),
        .wr_ok    (tx_wr_ok),
        .rd_ok    (tx_rd_ok),
        .err_flag (tx_underflow)
    );

    // Receive event: pin pushes add, DMA pops retire
    aud_evt_ctrl #(
        .DEPTH     (DEPTH),
        .MAX_THR   (MAX_THR),
        .INIT_PEND (0)
    ) u_rx_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr      (cfg_rx_thr),
        .pin_move (rx_wr_ok),
        .dma_move (rx_rd_ok),
        .evt      (rx_event)
    );

    // Transmit event: pin pops add, DMA pushes retire
    aud_evt_ctrl #(
        .DEPTH     (DEPTH),
        .MAX_THR   (MAX_THR),
        .INIT_PEND (1)
    ) u_tx_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .thr      (cfg_tx_thr),
        .pin_move (tx_rd_ok),
        .dma_move (tx_wr_ok),
        .evt      (tx_event)
    );

    // R3: an overflow flag rise is caused by a pin push in the cycle before
    p_ovf_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overflow) |-> $past(rx_pin_valid));

    // R4: an underflow flag rise is caused by a pin pop in the cycle before
    p_unf_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_underflow) |-> $past(tx_pin_rd));
endmodule

// File: tb/aud_dma_fifo_tb_top.sv
`timescale 1ns/1ps
// Bench for aud_dma_fifo: queue-based reference model compared every cycle.
module aud_dma_fifo_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_rx_thr = 6'd4;
    logic [5:0]  cfg_tx_thr = 6'd4;
    logic        rx_pin_valid = 1'b0;
    logic [31:0] rx_pin_data = '0;
    logic        rx_dma_rd = 1'b0;
    logic [31:0] rx_dma_data;
    logic        rx_event;
    logic        rx_overflow;
    logic        tx_dma_wr = 1'b0;
    logic [31:0] tx_dma_data = '0;
    logic        tx_pin_rd = 1'b0;
    logic [31:0] tx_pin_data;
    logic        tx_event;
    logic        tx_underflow;

    always #2 clk = ~clk;

    aud_dma_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_rx_thr(cfg_rx_thr), .cfg_tx_thr(cfg_tx_thr),
        .rx_pin_valid(rx_pin_valid), .rx_pin_data(rx_pin_data), .rx_dma_rd(rx_dma_rd),
        .rx_dma_data(rx_dma_data), .rx_event(rx_event), .rx_overflow(rx_overflow),
        .tx_dma_wr(tx_dma_wr), .tx_dma_data(tx_dma_data), .tx_pin_rd(tx_pin_rd),
        .tx_pin_data(tx_pin_data), .tx_event(tx_event), .tx_underflow(tx_underflow)
    );

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // Reference model state
    logic [31:0] rxq[$];
    logic [31:0] txq[$];
    int rx_pc = 0, rx_dc = 0, rx_pend = 0;
    int tx_pc = 0, tx_dc = 0, tx_pend = 1;
    bit m_ovf = 1'b0, m_unf = 1'b0;
    int rx_seq = 0, tx_seq = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic ev_step(inout int pc, inout int dc, inout int pend,
                           input int thr, input bit pm, input bit dm);
        bit s;
        bit c;
        s = pm && (pc + 1 >= thr);
        c = dm && (dc + 1 >= thr);
        if (pm) pc = s ? 0 : pc + 1;
        if (dm) dc = c ? 0 : dc + 1;
        if (s && c && pend != 0) begin
        end else if (s) begin
            if (pend < 255) pend++;
        end else if (c && pend != 0) begin
            pend--;
        end
    endtask

    // Compare every output with the model
    task automatic compare_all();
        chk(cur_req, "rx_event", {31'd0, rx_event}, {31'd0, rx_pend != 0});
        chk(cur_req, "tx_event", {31'd0, tx_event}, {31'd0, tx_pend != 0});
        chk("R3", "rx_overflow", {31'd0, rx_overflow}, {31'd0, m_ovf});
        chk("R4", "tx_underflow", {31'd0, tx_underflow}, {31'd0, m_unf});
        if (rxq.size() > 0) chk("R2", "rx_dma_data", rx_dma_data, rxq[0]);
        if (txq.size() > 0) chk("R2", "tx_pin_data", tx_pin_data, txq[0]);
    endtask

    // One cycle: drive at falling edge, model at rising edge, check at next falling edge
    task automatic cyc(input bit rxw, input bit rxr, input bit txw, input bit txr);
        bit rx_acc_w, rx_acc_r, tx_acc_w, tx_acc_r;
        rx_pin_valid = rxw;
        rx_pin_data  = 32'hA000_0000 + rx_seq;
        rx_dma_rd    = rxr;
        tx_dma_wr    = txw;
        tx_dma_data  = 32'h5000_0000 + tx_seq;
        tx_pin_rd    = txr;
        @(posedge clk);
        rx_acc_w = rxw && (rxq.size() < 64);
        rx_acc_r = rxr && (rxq.size() > 0);
        tx_acc_w = txw && (txq.size() < 64);
        tx_acc_r = txr && (txq.size() > 0);
        if (rxw && !rx_acc_w) m_ovf = 1'b1;
        if (txr && !tx_acc_r) m_unf = 1'b1;
        if (rx_acc_r) void'(rxq.pop_front());
        if (rx_acc_w) begin rxq.push_back(32'hA000_0000 + rx_seq); rx_seq++; end
        if (tx_acc_r) void'(txq.pop_front());
        if (tx_acc_w) begin txq.push_back(32'h5000_0000 + tx_seq); tx_seq++; end
        ev_step(rx_pc, rx_dc, rx_pend, int'(cfg_rx_thr), rx_acc_w, rx_acc_r);
        ev_step(tx_pc, tx_dc, tx_pend, int'(cfg_tx_thr), tx_acc_r, tx_acc_w);
        @(negedge clk);
        rx_pin_valid = 1'b0;
        rx_dma_rd    = 1'b0;
        tx_dma_wr    = 1'b0;
        tx_pin_rd    = 1'b0;
        compare_all();
    endtask

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000 && !done) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog (all requirements): actual hung expected finished");
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "rx_event", {31'd0, rx_event}, 32'd0);
        chk("R1", "tx_event", {31'd0, tx_event}, 32'd1);
        chk("R1", "rx_overflow", {31'd0, rx_overflow}, 32'd0);
        chk("R1", "tx_underflow", {31'd0, tx_underflow}, 32'd0);

        // R5: event rises one cycle after the threshold-completing push
        cur_req = "R5";
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0);
        chk("R5", "rx_event before batch", {31'd0, rx_event}, 32'd0);
        cyc(1, 0, 0, 0);
        chk("R5", "rx_event after batch", {31'd0, rx_event}, 32'd1);

        // R6: retirement after a batch of DMA pops
        cur_req = "R6";
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);
        chk("R6", "rx_event mid drain", {31'd0, rx_event}, 32'd1);
        cyc(0, 1, 0, 0);
        chk("R6", "rx_event drained", {31'd0, rx_event}, 32'd0);

        // R9: two batches pending need two retirements
        cur_req = "R9";
        for (int i = 0; i < 8; i++) cyc(1, 0, 0, 0);
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0);
        chk("R9", "rx_event one left", {31'd0, rx_event}, 32'd1);
        for (int i = 0; i < 4; i++) cyc(0, 1, 0, 0);
        chk("R9", "rx_event none left", {31'd0, rx_event}, 32'd0);

        // R8: add and retire on the same edge, then on adjacent edges
        cur_req = "R8";
        for (int i = 0; i < 7; i++) cyc(1, 0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0);
        cyc(1, 1, 0, 0);
        chk("R8", "rx_event same-edge", {31'd0, rx_event}, 32'd1);
        for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0);
        cyc(1, 0, 0, 0);
        cyc(0, 1, 0, 0);
        chk("R8", "rx_event adjacent", {31'd0, rx_event}, {31'd0, rx_pend != 0});
        chk("R8", "rx_event adjacent high", {31'd0, rx_event}, 32'd1);
        chk("R8", "no overflow", {31'd0, rx_overflow}, 32'd0);
        while (rxq.size() > 0) cyc(0, 1, 0, 0);

        // R10: DMA pops on empty receive FIFO are ignored
        cur_req = "R10";
        for (int i = 0; i < 5; i++) cyc(0, 1, 0, 0);
        for (int i = 0; i < 4; i++) cyc(1, 0, 0, 0);
        chk("R10", "rx_event after ignored pops", {31'd0, rx_event}, {31'd0, rx_pend != 0});
        while (rxq.size() > 0) cyc(0, 1, 0, 0);

        // R3: overflow on a push into a full FIFO
        cur_req = "R3";
        cfg_rx_thr = 6'd32;
        for (int i = 0; i < 64; i++) cyc(1, 0, 0, 0);
        chk("R3", "rx_overflow before", {31'd0, rx_overflow}, 32'd0);
        cyc(1, 0, 0, 0);
        chk("R3", "rx_overflow set", {31'd0, rx_overflow}, 32'd1);
        for (int i = 0; i < 64; i++) cyc(0, 1, 0, 0);
        chk("R3", "rx_overflow sticky", {31'd0, rx_overflow}, 32'd1);

        // R7: transmit events
        cur_req = "R7";
        chk("R7", "tx_event initial", {31'd0, tx_event}, 32'd1);
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0);
        chk("R7", "tx_event after fill", {31'd0, tx_event}, 32'd0);
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 1);
        chk("R7", "tx_event after pin pops", {31'd0, tx_event}, 32'd1);

        // R4: pop from empty transmit FIFO
        cur_req = "R4";
        chk("R4", "tx_underflow before", {31'd0, tx_underflow}, 32'd0);
        cyc(0, 0, 0, 1);
        chk("R4", "tx_underflow set", {31'd0, tx_underflow}, 32'd1);

        // R10: DMA push into a full transmit FIFO is ignored; R8 on transmit side
        cur_req = "R10";
        for (int i = 0; i < 65; i++) cyc(0, 0, 1, 0);
        chk("R10", "tx_event after extra push", {31'd0, tx_event}, {31'd0, tx_pend != 0});
        cur_req = "R8";
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1);
        cyc(0, 0, 1, 1);
        chk("R8", "tx_event coincident", {31'd0, tx_event}, 32'd1);
        cur_req = "R2";
        while (txq.size() > 0) cyc(0, 0, 0, 1);
        chk("R4", "tx_underflow sticky", {31'd0, tx_underflow}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule